// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

This block is a single-channel DMA engine. Software builds a chain of 16-byte descriptors in memory, writes the address of the first one into the block, picks a direction and sets the run bit. The engine then reads each descriptor, moves its data word by word, and follows the chain until it reaches a descriptor marked as the last one. Data moves either from memory to a peripheral transmit stream or from a peripheral receive stream into memory.

Memory is reached through one request/grant port. The port serves both the descriptor fetches and the data accesses. A request stays up until it is granted, and read data and the error flag are valid in the grant cycle. Every way the channel can stop leaves a 4-bit outcome code in the channel register and raises a pending flag. An enable bit can route that flag to the interrupt output.

Top module: `chain_dma`

## Requirements
- R1: After reset every register reads zero. `irq`, `mem_req`, `tx_valid` and `rx_ready` are low.
- R2: Register offset 0x00 is global control. Bit 0 is the engine enable and reads back as written. A channel that is set running while the enable is 0 issues no memory request until the enable is set.
- R3: A descriptor is four words at a 16-byte-aligned address. At +0 is a flags word: bits 15:0 are the byte count, bit 30 must be 1, and bit 31 marks the last descriptor. +4 holds the buffer address and +8 holds the next descriptor's address. The engine moves ceil(count/4) words, so a count of 0 moves nothing.
- R4: With direction 0, words are read from consecutive buffer addresses and emitted on `tx_data` in order. Each word is held until `tx_ready` is high.
- R5: With direction 1, each word accepted from the receive stream is written to the next consecutive buffer address. Memory writes occur only in direction 1.
- R6: Offset 0x0C holds the first descriptor address. Offset 0x10 is channel control, with run at bit 7, direction at bit 22 and the outcome code at bits 3:0. After a descriptor without the last flag, the next one is fetched from its +8 address. When a chain ends normally the code becomes 0xF and run clears.
- R7: A flags word with bit 30 clear, or an error response during any descriptor fetch, stops the channel with code 3.
- R8: An error response on a data read or write stops the channel with code 4. No further memory access follows.
- R9: In direction 1, `rx_last` with a word that is not the final word of the last descriptor stops the channel with code 5, after that word is written. `rx_last` on the final word still gives 0xF.
- R10: Every stop sets bit 0 of offset 0x08. Writing 1 to that bit clears it. `irq` is that bit ANDed with bit 0 of offset 0x04.
- R11: A write with bit 8 set to offset 0x00 clears all registers and aborts any transfer. From the next cycle on, no request or stream handshake is offered.
- R12: Writes to channel control while the channel is busy are ignored.
- R13: While `mem_req` is high and not granted, the request, address, write flag and write data hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after the address |
| irq | output | 1 | Interrupt: pending flag gated by enable |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_gnt | input | 1 | Memory grant |
| mem_err | input | 1 | Error response, valid with grant |
| mem_rdata | input | 32 | Read data, valid with grant |
| tx_valid | output | 1 | Transmit stream word valid |
| tx_data | output | 32 | Transmit stream word |
| tx_ready | input | 1 | Peripheral accepts transmit word |
| rx_valid | input | 1 | Receive stream word valid |
| rx_data | input | 32 | Receive stream word |
| rx_last | input | 1 | Peripheral has no more data after this word |
| rx_ready | output | 1 | Engine accepts receive word |

## Verification
The bench targets the following corner cases:
- A 5-byte count: rounding it down would drop a word from the transmit sequence.
- A zero-length descriptor: mishandling it would emit or write stray words.
- `rx_last` arriving both early and on the final word: getting this wrong gives a false early-end code or a false success.
- Error responses on a data word and on a descriptor fetch: mixing them up gives the wrong outcome code or lets the transfer continue.
- A missing format bit part-way through the chain: a design that ignores it keeps moving data.
- A direction write while busy: if honoured, it would turn a read transfer into writes.
- A soft reset mid-transfer: an engine that kept its state would keep requesting memory.

// File: rtl/chain_dma_pkg.sv
package chain_dma_pkg;

  // register byte offsets
  localparam int OFS_GCTL = 0;
  localparam int OFS_IEN  = 4;
  localparam int OFS_IST  = 8;
  localparam int OFS_DPTR = 12;
  localparam int OFS_CCTL = 16;

  // bit positions
  localparam int GCTL_EN_BIT  = 0;
  localparam int GCTL_RST_BIT = 8;
  localparam int CCTL_RUN_BIT = 7;
  localparam int CCTL_DIR_BIT = 22;
  localparam int FLG_FMT_BIT  = 30;
  localparam int FLG_END_BIT  = 31;

  typedef enum logic [3:0] {
    EV_NONE  = 4'h0,
    EV_UNDER = 4'h1,
    EV_OVER  = 4'h2,
    EV_DESC  = 4'h3,
    EV_DATA  = 4'h4,
    EV_EARLY = 4'h5,
    EV_OK    = 4'hF
  } ev_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH,
    S_MRD,
    S_PUSH,
    S_PULL,
    S_MWR,
    S_NEXT
  } st_e;

endpackage

// File: rtl/chain_dma_regs.sv
module chain_dma_regs
  import chain_dma_pkg::*;
#(
  parameter int REG_AW = 5,
  parameter int AW     = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              eng_busy,
  input  logic              eng_done,
  input  logic [3:0]        eng_code,
  output logic              sreset,
  output logic              en,
  output logic              ien,
  output logic              ist,
  output logic [AW-1:0]     dptr,
  output logic              run,
  output logic              dir
);

  logic [3:0]  code_q;
  logic [31:0] rd_mux;
  logic        unused_wbits;

  logic wr_gctl, wr_ien, wr_ist, wr_dptr, wr_cctl;

  assign wr_gctl = reg_wr && (int'(reg_addr) == OFS_GCTL);
  assign wr_ien  = reg_wr && (int'(reg_addr) == OFS_IEN);
  assign wr_ist  = reg_wr && (int'(reg_addr) == OFS_IST);
  assign wr_dptr = reg_wr && (int'(reg_addr) == OFS_DPTR);
  assign wr_cctl = reg_wr && (int'(reg_addr) == OFS_CCTL);

  assign sreset       = wr_gctl && reg_wdata[GCTL_RST_BIT];
  assign unused_wbits = reg_wdata[1];

  always_ff @(posedge clk) begin
    if (rst || sreset) begin
      en     <= 1'b0;
      ien    <= 1'b0;
      ist    <= 1'b0;
      dptr   <= '0;
      run    <= 1'b0;
      dir    <= 1'b0;
      code_q <= EV_NONE;
    end else begin
      if (wr_gctl) en  <= reg_wdata[GCTL_EN_BIT];
      if (wr_ien)  ien <= reg_wdata[0];
      if (eng_done)
        ist <= 1'b1;
      else if (wr_ist && reg_wdata[0])
        ist <= 1'b0;
      if (wr_dptr) dptr <= {reg_wdata[AW-1:2], 2'b00};
      if (eng_done) begin
        run    <= 1'b0;
        code_q <= eng_code;
      end else if (wr_cctl && !eng_busy) begin
        run <= reg_wdata[CCTL_RUN_BIT];
        dir <= reg_wdata[CCTL_DIR_BIT];
        if (reg_wdata[CCTL_RUN_BIT]) code_q <= EV_NONE;
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    case (int'(reg_addr))
      OFS_GCTL: rd_mux[GCTL_EN_BIT] = en;
      OFS_IEN:  rd_mux[0] = ien;
      OFS_IST:  rd_mux[0] = ist;
      OFS_DPTR: rd_mux = 32'(dptr);
      OFS_CCTL: begin
        rd_mux[CCTL_DIR_BIT] = dir;
        rd_mux[CCTL_RUN_BIT] = run;
        rd_mux[3:0]          = code_q;
      end
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end

endmodule

// File: rtl/chain_dma_engine.sv
module chain_dma_engine
  import chain_dma_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CNT_W = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sreset,
  input  logic          en,
  input  logic          run,
  input  logic          dir,
  input  logic [AW-1:0] dptr,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_gnt,
  input  logic          mem_err,
  input  logic [31:0]   mem_rdata,
  output logic          tx_valid,
  output logic [31:0]   tx_data,
  input  logic          tx_ready,
  input  logic          rx_valid,
  input  logic [31:0]   rx_data,
  input  logic          rx_last,
  output logic          rx_ready,
  output logic          busy,
  output logic          done,
  output logic [3:0]    code
);

  localparam int WC_W = CNT_W - 1;
  localparam logic [AW-1:0] STEP = AW'(4);

  st_e             state;
  logic [1:0]      widx;
  logic [AW-1:0]   maddr;
  logic [AW-1:0]   buf_a;
  logic [AW-1:0]   next_a;
  logic [WC_W-1:0] wleft;
  logic            last_d;
  logic            early;
  logic [31:0]     data_q;
  logic            done_q;
  logic [3:0]      code_q;

  always_ff @(posedge clk) begin
    if (rst || sreset) begin
      state  <= S_IDLE;
      widx   <= '0;
      maddr  <= '0;
      buf_a  <= '0;
      next_a <= '0;
      wleft  <= '0;
      last_d <= 1'b0;
      early  <= 1'b0;
      data_q <= '0;
      done_q <= 1'b0;
      code_q <= EV_NONE;
    end else begin
      done_q <= 1'b0;
      case (state)
        S_IDLE: begin
          if (run && en && !done_q) begin
            maddr <= dptr;
            widx  <= '0;
            early <= 1'b0;
            state <= S_FETCH;
          end
        end
        S_FETCH: begin
          if (mem_gnt) begin
            if (mem_err) begin
              state  <= S_IDLE;
              done_q <= 1'b1;
              code_q <= EV_DESC;
            end else begin
              case (widx)
                2'd0: begin
                  if (!mem_rdata[FLG_FMT_BIT]) begin
                    state  <= S_IDLE;
                    done_q <= 1'b1;
                    code_q <= EV_DESC;
                  end else begin
                    last_d <= mem_rdata[FLG_END_BIT];
                    wleft  <= WC_W'(({1'b0, mem_rdata[CNT_W-1:0]}
                                     + (CNT_W+1)'(3)) >> 2);
                    widx   <= 2'd1;
                    maddr  <= maddr + STEP;
                  end
                end
                2'd1: begin
                  buf_a <= {mem_rdata[AW-1:2], 2'b00};
                  widx  <= 2'd2;
                  maddr <= maddr + STEP;
                end
                default: begin
                  next_a <= {mem_rdata[AW-1:2], 2'b00};
                  maddr  <= buf_a;
                  widx   <= 2'd0;
                  if (wleft == '0) state <= S_NEXT;
                  else if (dir)    state <= S_PULL;
                  else             state <= S_MRD;
                end
              endcase
            end
          end
        end
        S_MRD: begin
          if (mem_gnt) begin
            if (mem_err) begin
              state  <= S_IDLE;
              done_q <= 1'b1;
              code_q <= EV_DATA;
            end else begin
              data_q <= mem_rdata;
              maddr  <= maddr + STEP;
              wleft  <= wleft - 1'b1;
              state  <= S_PUSH;
            end
          end
        end
        S_PUSH: begin
          if (tx_ready) state <= (wleft == '0) ? S_NEXT : S_MRD;
        end
        S_PULL: begin
          if (rx_valid) begin
            data_q <= rx_data;
            early  <= rx_last;
            wleft  <= wleft - 1'b1;
            state  <= S_MWR;
          end
        end
        S_MWR: begin
          if (mem_gnt) begin
            if (mem_err) begin
              state  <= S_IDLE;
              done_q <= 1'b1;
              code_q <= EV_DATA;
            end else begin
              maddr <= maddr + STEP;
              if (early && !(wleft == '0 && last_d)) begin
                state  <= S_IDLE;
                done_q <= 1'b1;
                code_q <= EV_EARLY;
              end else if (wleft == '0) begin
                state <= S_NEXT;
              end else begin
                state <= S_PULL;
              end
            end
          end
        end
        S_NEXT: begin
          if (last_d) begin
            state  <= S_IDLE;
            done_q <= 1'b1;
            code_q <= EV_OK;
          end else begin
            maddr <= next_a;
            widx  <= '0;
            state <= S_FETCH;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign mem_req   = (state == S_FETCH) || (state == S_MRD) || (state == S_MWR);
  assign mem_we    = (state == S_MWR);
  assign mem_addr  = maddr;
  assign mem_wdata = data_q;
  assign tx_valid  = (state == S_PUSH);
  assign tx_data   = data_q;
  assign rx_ready  = (state == S_PULL);
  assign busy      = (state != S_IDLE) || done_q;
  assign done      = done_q;
  assign code      = code_q;

endmodule

// File: rtl/chain_dma.sv
module chain_dma
  import chain_dma_pkg::*;
#(
  parameter int REG_AW = 5,
  parameter int AW     = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_gnt,
  input  logic              mem_err,
  input  logic [31:0]       mem_rdata,
  output logic              tx_valid,
  output logic [31:0]       tx_data,
  input  logic              tx_ready,
  input  logic              rx_valid,
  input  logic [31:0]       rx_data,
  input  logic              rx_last,
  output logic              rx_ready
);

  logic          sreset;
  logic          en, ien, ist, run, ch_dir;
  logic [AW-1:0] dptr;
  logic          eng_busy, eng_done;
  logic [3:0]    eng_code;

  chain_dma_regs #(.REG_AW(REG_AW), .AW(AW)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .eng_busy  (eng_busy),
    .eng_done  (eng_done),
    .eng_code  (eng_code),
    .sreset    (sreset),
    .en        (en),
    .ien       (ien),
    .ist       (ist),
    .dptr      (dptr),
    .run       (run),
    .dir       (ch_dir)
  );

  chain_dma_engine #(.AW(AW), .CNT_W(CNT_W)) u_eng (
    .clk       (clk),
    .rst       (rst),
    .sreset    (sreset),
    .en        (en),
    .run       (run),
    .dir       (ch_dir),
    .dptr      (dptr),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_gnt   (mem_gnt),
    .mem_err   (mem_err),
    .mem_rdata (mem_rdata),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .tx_ready  (tx_ready),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data),
    .rx_last   (rx_last),
    .rx_ready  (rx_ready),
    .busy      (eng_busy),
    .done      (eng_done),
    .code      (eng_code)
  );

  assign irq = ien && ist;

endmodule

// File: rtl/chain_dma_sva.sv
module chain_dma_sva #(
  parameter int REG_AW = 5,
  parameter int AW     = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [REG_AW-1:0] reg_addr,
  input logic              wd_b0,
  input logic              wd_b8,
  input logic              irq,
  input logic              mem_req,
  input logic              mem_we,
  input logic [AW-1:0]     mem_addr,
  input logic [31:0]       mem_wdata,
  input logic              mem_gnt,
  input logic              tx_valid,
  input logic [31:0]       tx_data,
  input logic              tx_ready,
  input logic              rx_ready,
  input logic              eng_done,
  input logic              ch_dir
);

  logic sr, clr;
  assign sr  = reg_wr && (int'(reg_addr) == 0) && wd_b8;
  assign clr = reg_wr && (int'(reg_addr) == 8) && wd_b0;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_gnt && !sr) |=> (mem_req && $stable(mem_addr) &&
                                      $stable(mem_we) && $stable(mem_wdata))); // R13

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready && !sr) |=> (tx_valid && $stable(tx_data))); // R4

  AST_WR_DIR: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> ch_dir); // R5

  AST_ONE_PORT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({tx_valid, rx_ready, mem_req})); // R5

  AST_SRESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    sr |=> (!mem_req && !tx_valid && !rx_ready && !irq)); // R11

  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (clr && !eng_done && !sr) |=> !irq); // R10

endmodule

bind chain_dma chain_dma_sva #(.REG_AW(REG_AW), .AW(AW)) u_sva (
  .clk       (clk),
  .rst       (rst),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .wd_b0     (reg_wdata[0]),
  .wd_b8     (reg_wdata[8]),
  .irq       (irq),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_gnt   (mem_gnt),
  .tx_valid  (tx_valid),
  .tx_data   (tx_data),
  .tx_ready  (tx_ready),
  .rx_ready  (rx_ready),
  .eng_done  (eng_done),
  .ch_dir    (ch_dir)
);

// File: tb/chain_dma_tb.sv
module chain_dma_tb;

  localparam logic [4:0] A_GCTL = 5'd0;
  localparam logic [4:0] A_IEN  = 5'd4;
  localparam logic [4:0] A_IST  = 5'd8;
  localparam logic [4:0] A_DPTR = 5'd12;
  localparam logic [4:0] A_CCTL = 5'd16;
  localparam logic [31:0] FMT  = 32'h4000_0000;
  localparam logic [31:0] LAST = 32'h8000_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  logic        mem_req, mem_we, mem_gnt, mem_err;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        tx_valid, tx_ready = 1'b1;
  logic [31:0] tx_data;
  logic        rx_valid = 1'b0, rx_last = 1'b0, rx_ready;
  logic [31:0] rx_data = '0;

  logic [31:0] mem [0:1023];
  logic        gnt_ok = 1'b1;
  logic        stall = 1'b0;
  logic        err_on = 1'b0;
  logic [31:0] err_a = '0;
  logic        rx_pop = 1'b0;
  int          gcnt = 0;
  int          cyc = 0;
  int          n_run = 0;
  int          n_fail = 0;

  logic [31:0] exp_tx [$];
  logic [63:0] exp_wr [$];
  logic [32:0] rx_q [$];

  chain_dma u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_err(mem_err),
    .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_last(rx_last), .rx_ready(rx_ready)
  );

  always #2.5ns clk = ~clk;

  assign mem_gnt   = mem_req && gnt_ok;
  assign mem_err   = mem_gnt && err_on && (mem_addr == err_a);
  assign mem_rdata = mem[mem_addr[11:2]];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // stimulus patterns, updated just after each rising edge
  always begin
    @(posedge clk);
    #1ns;
    gcnt++;
    if (rx_pop) begin
      void'(rx_q.pop_front());
      rx_pop = 1'b0;
    end
    gnt_ok   = !stall || (gcnt % 3 != 1);
    tx_ready = !stall || (gcnt % 4 != 2);
    rx_valid = (rx_q.size() > 0) && (!stall || (gcnt % 5 != 3));
    if (rx_q.size() > 0) {rx_last, rx_data} = rx_q[0];
    else begin rx_last = 1'b0; rx_data = '0; end
  end

  // reference comparison every clock, mid-cycle
  always @(negedge clk) begin
    if (!rst) begin
      if (tx_valid && tx_ready) begin
        if (exp_tx.size() == 0) chk("R4 unexpected tx word", tx_data, 32'hx);
        else chk("R4 tx word order", tx_data, exp_tx.pop_front());
      end
      if (mem_req && mem_we && mem_gnt && !mem_err) begin
        if (exp_wr.size() == 0) chk("R5 unexpected write", mem_addr, 32'hx);
        else begin
          logic [63:0] e;
          e = exp_wr.pop_front();
          chk("R5 write address", mem_addr, e[63:32]);
          chk("R5 write data", mem_wdata, e[31:0]);
        end
        mem[mem_addr[11:2]] = mem_wdata;
      end
      if (rx_valid && rx_ready) rx_pop = 1'b1;
    end
  end

  always begin
    @(posedge clk);
    cyc++;
    if (cyc == 150000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(posedge clk); #1ns;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1ns;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(posedge clk); #1ns;
    reg_addr = a;
    @(posedge clk); #1ns;
    d = reg_rdata;
  endtask

  task automatic put(input int a, input logic [31:0] fl, input int b, input int br);
    mem[a/4]     = fl;
    mem[a/4 + 1] = 32'(b);
    mem[a/4 + 2] = 32'(br);
    mem[a/4 + 3] = 32'h5A5A_5A5A;
  endtask

  task automatic exp_rd(input int b, input int n);
    for (int k = 0; k < n; k++) exp_tx.push_back(mem[b/4 + k]);
  endtask

  task automatic go(input int d, input logic dr);
    wr(A_DPTR, 32'(d));
    wr(A_CCTL, (32'(dr) << 22) | 32'h80);
  endtask

  task automatic wait_done(output logic [31:0] v);
    for (int i = 0; i < 4000; i++) begin
      rd(A_CCTL, v);
      if (!v[7]) break;
    end
  endtask

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 1024; i++) mem[i] = 32'hC0DE_0000 + 32'(i);
    repeat (4) @(posedge clk);
    #1ns rst = 1'b0;

    // R1 reset state
    rd(A_GCTL, v); chk("R1 gctl", v, 0);
    rd(A_IEN, v);  chk("R1 ien", v, 0);
    rd(A_IST, v);  chk("R1 ist", v, 0);
    rd(A_DPTR, v); chk("R1 dptr", v, 0);
    rd(A_CCTL, v); chk("R1 cctl", v, 0);
    chk("R1 outputs", {28'd0, irq, mem_req, tx_valid, rx_ready}, 0);

    // R2 enable readback
    wr(A_GCTL, 32'h1);
    rd(A_GCTL, v); chk("R2 enable readback", v, 32'h1);
    wr(A_IEN, 32'h1);

    // R3 R4 R6 three-descriptor read chain, 5-byte count, stalls
    stall = 1'b1;
    put(32'h100, FMT | 8, 32'h400, 32'h110);
    put(32'h110, FMT | 5, 32'h500, 32'h120);
    put(32'h120, FMT | LAST | 4, 32'h600, 0);
    exp_rd(32'h400, 2); exp_rd(32'h500, 2); exp_rd(32'h600, 1);
    go(32'h100, 1'b0);
    wait_done(v);
    chk("R6 chain end code", v, 32'h0000_000F);
    chk("R3 word count", 32'(exp_tx.size()), 0);
    rd(A_IST, v); chk("R10 pending set", v, 32'h1);
    chk("R10 irq raised", 32'(irq), 1);

    // R10 write-one-to-clear
    wr(A_IST, 32'h1);
    rd(A_IST, v); chk("R10 pending cleared", v, 0);
    chk("R10 irq cleared", 32'(irq), 0);

    // R5 write chain, rx_last on final word
    put(32'h140, FMT | 12, 32'h800, 32'h150);
    put(32'h150, FMT | LAST | 8, 32'h900, 0);
    for (int k = 0; k < 5; k++) begin
      logic [31:0] d;
      d = 32'hA500_0000 + 32'(k);
      rx_q.push_back({(k == 4), d});
      exp_wr.push_back({(k < 3) ? 32'h800 + 32'(4*k) : 32'h900 + 32'(4*(k-3)), d});
    end
    go(32'h140, 1'b1);
    wait_done(v);
    chk("R5 R9 success with dir", v, 32'h0040_000F);
    chk("R5 all words written", 32'(exp_wr.size()), 0);
    wr(A_IST, 32'h1);

    // R7 missing format bit on second descriptor
    put(32'h180, FMT | 4, 32'h400, 32'h190);
    put(32'h190, LAST | 4, 32'h440, 0);
    exp_rd(32'h400, 1);
    go(32'h180, 1'b0);
    wait_done(v);
    chk("R7 format error code", v, 32'h3);
    chk("R7 no data after bad desc", 32'(exp_tx.size()), 0);

    // R9 early end
    put(32'h1A0, FMT | LAST | 12, 32'hA00, 0);
    rx_q.push_back({1'b0, 32'hBEE0_0001});
    rx_q.push_back({1'b1, 32'hBEE0_0002});
    exp_wr.push_back({32'hA00, 32'hBEE0_0001});
    exp_wr.push_back({32'hA04, 32'hBEE0_0002});
    go(32'h1A0, 1'b1);
    wait_done(v);
    chk("R9 early end code", v, 32'h0040_0005);
    chk("R9 words written", 32'(exp_wr.size()), 0);

    // R8 data read error on third word
    put(32'h1C0, FMT | LAST | 16, 32'h400, 0);
    err_a = 32'h408; err_on = 1'b1;
    exp_rd(32'h400, 2);
    go(32'h1C0, 1'b0);
    wait_done(v);
    chk("R8 data error code", v, 32'h4);
    chk("R8 stops after error", 32'(exp_tx.size()), 0);

    // R7 error on descriptor fetch
    put(32'h260, FMT | LAST | 4, 32'h400, 0);
    err_a = 32'h264;
    go(32'h260, 1'b0);
    wait_done(v);
    chk("R7 fetch error code", v, 32'h3);
    err_on = 1'b0;

    // R10 gating by interrupt enable
    wr(A_IST, 32'h1);
    wr(A_IEN, 32'h0);
    put(32'h1E0, FMT | LAST | 4, 32'h440, 0);
    exp_rd(32'h440, 1);
    go(32'h1E0, 1'b0);
    wait_done(v);
    rd(A_IST, v); chk("R10 pending without enable", v, 32'h1);
    chk("R10 irq gated", 32'(irq), 0);
    wr(A_IEN, 32'h1);
    chk("R10 irq after enable", 32'(irq), 1);
    wr(A_IST, 32'h1);

    // R12 control write while busy ignored
    put(32'h200, FMT | LAST | 32, 32'h400, 0);
    exp_rd(32'h400, 8);
    go(32'h200, 1'b0);
    repeat (4) @(posedge clk);
    wr(A_CCTL, 32'h0040_0080);
    wait_done(v);
    chk("R12 busy write ignored", v, 32'h0000_000F);
    chk("R12 read words", 32'(exp_tx.size()), 0);

    // R3 zero-length descriptor skipped
    put(32'h220, FMT | 0, 32'h3F0, 32'h230);
    put(32'h230, FMT | LAST | 4, 32'h480, 0);
    exp_rd(32'h480, 1);
    go(32'h220, 1'b0);
    wait_done(v);
    chk("R3 zero count code", v, 32'hF);
    chk("R3 zero count words", 32'(exp_tx.size()), 0);

    // R2 run while disabled does nothing
    wr(A_GCTL, 32'h0);
    go(32'h220, 1'b0);
    begin
      logic seen;
      seen = 1'b0;
      repeat (20) begin @(negedge clk); if (mem_req) seen = 1'b1; end
      chk("R2 no request while disabled", 32'(seen), 0);
    end
    rd(A_CCTL, v); chk("R2 run pending", v, 32'h80);
    exp_rd(32'h480, 1);
    wr(A_GCTL, 32'h1);
    wait_done(v);
    chk("R2 runs once enabled", v, 32'hF);

    // R11 soft reset mid-transfer
    put(32'h240, FMT | LAST | 64, 32'h400, 0);
    exp_rd(32'h400, 16);
    go(32'h240, 1'b0);
    repeat (10) @(posedge clk);
    wr(A_GCTL, 32'h101);
    exp_tx.delete();
    chk("R11 quiet after reset", {29'd0, mem_req, tx_valid, rx_ready}, 0);
    rd(A_GCTL, v); chk("R11 gctl cleared", v, 0);
    rd(A_IST, v);  chk("R11 ist cleared", v, 0);
    rd(A_DPTR, v); chk("R11 dptr cleared", v, 0);
    rd(A_CCTL, v); chk("R11 cctl cleared", v, 0);
    chk("R11 irq low", 32'(irq), 0);
    repeat (20) @(posedge clk);

    stall = 1'b0;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule